// File: doc/BRIEF.md
# GPIO and Interrupt Expander

This block puts a set of output pins, a set of input pins and a pending-interrupt register behind a simple parallel host bus. The host writes whole output registers to drive pins, reads input registers to get the synchronized level of the input pins, and reads a shared acknowledge register to learn which interrupt sources have fired since the last acknowledge.

Each of the first `N_IRQ` input pins is also an interrupt source. A rising edge on the synchronized pin sets a sticky pending bit. Any pending bit raises a single interrupt line, which the host senses on its rising edge. The expander has no per-source mask, so the host filters the sources itself. To acknowledge, the host writes a fixed pattern to the acknowledge register. This write clears every pending bit at once and drops the line for at least one cycle, so a later event produces a fresh rising edge. A build-time option inverts the pattern.

Top module: `gpio_irq_expander`

## Requirements
- R1: The register index is the byte address shifted right by 1 when `BUS_W` is 16, or by 2 when `BUS_W` is 32. The address bits below that shift are ignored.
- R2: Pin N belongs to register (start index + N / `REG_W`), at bit (N mod `REG_W`). This holds for both the output bank (start `OUT_START`) and the input bank (start `IN_START`).
- R3: A write to an output register loads all of its pins from `wdata_i[REG_W-1:0]`. Pins of other registers keep their values, and without a write the output pins are stable.
- R4: After reset the output pins equal `OUT_INIT`, so the host can restore them by rewriting the registers.
- R5: A read of an input register returns the input levels after a two-flop synchronizer. `rdata_o` updates on the clock edge that samples `rd_i` and holds its value until the next read.
- R6: A rising edge of synchronized input k (k < `N_IRQ`) sets pending bit k, which stays set until an acknowledge. A falling edge or a steady level sets nothing.
- R7: A read of the acknowledge register (`ACK_REG`) returns the pending bitmap: bit k is source k, and the upper bits are zero.
- R8: A write to the acknowledge register clears all pending bits when `wdata_i[15:0]` is 16'hFFFF, or 16'h0000 when `INV_ACK` is 1. Any other value is ignored.
- R9: `irq_o` is high exactly when a pending bit is set, and it is low in the cycle after an acknowledge write.
- R10: When a new event lands in the same cycle as an acknowledge, its pending bit ends up set. `irq_o` is low for one cycle and then high again.
- R11: Reads of any index other than the input registers and the acknowledge register return zero, and writes to such indices change nothing.
- R12: After reset, no bit is pending, `irq_o` is low and `rdata_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | BUS_W | Write data |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| rdata_o | output | BUS_W | Registered read data |
| in_pins_i | input | N_IN | Input pins, asynchronous |
| out_pins_o | output | N_OUT | Output pins |
| irq_o | output | 1 | Interrupt to the host, active high, rising-edge sensed |

## Verification
The assertions assume that `rd_i` and `wr_i` are never both high, and that a write is one strobe per access with address and data held stable for that cycle. The bench drives every bus access at the falling edge and releases it one cycle later, so these assumptions hold. The properties on the pending register also assume that the input pins change at most once per settle window. The bench therefore holds each pin pattern for several cycles. The only exception is the coincidence case, where the pin is deliberately timed so that its edge reaches the pending register in the same cycle as the acknowledge.

// File: rtl/gie_pkg.sv
package gie_pkg;
  function automatic int bus_shift(input int bus_w);
    return (bus_w == 32) ? 2 : 1;
  endfunction

  function automatic int ceil_div(input int a, input int b);
    return (a + b - 1) / b;
  endfunction
endpackage

// File: rtl/gie_sync_edge.sv
module gie_sync_edge #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign lvl_o  = s2_q;
  assign rise_o = s2_q & ~s3_q;
endmodule

// File: rtl/gie_out_bank.sv
module gie_out_bank import gie_pkg::*; #(
  parameter int                 REG_W  = 8,
  parameter int                 N_PINS = 12,
  parameter int                 N_REGS = ceil_div(N_PINS, REG_W),
  parameter logic [N_PINS-1:0]  INIT   = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_REGS-1:0] we_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [N_PINS-1:0] q_o
);
  for (genvar k = 0; k < N_REGS; k++) begin : g_reg
    localparam int LO = k * REG_W;
    // last register may be partially populated
    localparam int W  = (N_PINS - LO < REG_W) ? (N_PINS - LO) : REG_W;
    logic [W-1:0] r_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      r_q <= INIT[LO +: W];
      else if (we_i[k]) r_q <= wdata_i[W-1:0];
    end

    assign q_o[LO +: W] = r_q;
  end
endmodule

// File: rtl/gie_pend.sv
module gie_pend #(
  parameter int N = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ack_i,
  input  logic [N-1:0] rise_i,
  output logic [N-1:0] pend_o,
  output logic         irq_o
);
  logic [N-1:0] pend_q, pend_d;
  logic         irq_q;

  // new events win over a same-cycle ack
  assign pend_d = (ack_i ? '0 : pend_q) | rise_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      irq_q  <= ~ack_i & (|pend_d);
    end
  end

  assign pend_o = pend_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/gpio_irq_expander.sv
module gpio_irq_expander import gie_pkg::*; #(
  parameter int               BUS_W     = 16,
  parameter int               REG_W     = 8,
  parameter int               ADDR_W    = 8,
  parameter int               N_OUT     = 12,
  parameter int               N_IN      = 10,
  parameter int               N_IRQ     = 10,
  parameter int               OUT_START = 0,
  parameter int               IN_START  = 2,
  parameter int               ACK_REG   = 4,
  parameter bit               INV_ACK   = 1'b0,
  parameter logic [N_OUT-1:0] OUT_INIT  = 12'h5A3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  input  logic              rd_i,
  input  logic              wr_i,
  output logic [BUS_W-1:0]  rdata_o,
  input  logic [N_IN-1:0]   in_pins_i,
  output logic [N_OUT-1:0]  out_pins_o,
  output logic              irq_o
);
  localparam int          SHIFT  = bus_shift(BUS_W);
  localparam int          IDX_W  = ADDR_W - SHIFT;
  localparam int          N_OREG = ceil_div(N_OUT, REG_W);
  localparam int          N_IREG = ceil_div(N_IN, REG_W);
  localparam int          IN_PAD = N_IREG * REG_W;
  localparam logic [15:0] ACK_PAT = INV_ACK ? 16'h0000 : 16'hFFFF;

  logic [IDX_W-1:0]  idx;
  logic              unused_lo;
  logic              ack_sel, ack_hit;
  logic [N_OREG-1:0] out_we;
  logic [N_IN-1:0]   in_lvl, in_rise;
  logic [IN_PAD-1:0] in_pad;
  logic [N_IRQ-1:0]  pend;
  logic [BUS_W-1:0]  rd_val, rdata_q;

  assign idx       = addr_i[ADDR_W-1:SHIFT];
  assign unused_lo = ^addr_i[SHIFT-1:0];
  assign ack_sel   = (32'(idx) == 32'(ACK_REG));
  assign ack_hit   = wr_i & ack_sel & (wdata_i[15:0] == ACK_PAT);

  for (genvar k = 0; k < N_OREG; k++) begin : g_owe
    assign out_we[k] = wr_i & (32'(idx) == 32'(OUT_START + k));
  end

  gie_out_bank #(
    .REG_W (REG_W),
    .N_PINS(N_OUT),
    .N_REGS(N_OREG),
    .INIT  (OUT_INIT)
  ) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (out_we),
    .wdata_i(wdata_i[REG_W-1:0]),
    .q_o    (out_pins_o)
  );

  gie_sync_edge #(.W(N_IN)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (in_pins_i),
    .lvl_o (in_lvl),
    .rise_o(in_rise)
  );

  gie_pend #(.N(N_IRQ)) u_pend (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ack_i (ack_hit),
    .rise_i(in_rise[N_IRQ-1:0]),
    .pend_o(pend),
    .irq_o (irq_o)
  );

  assign in_pad = IN_PAD'(in_lvl);

  always_comb begin
    rd_val = '0;
    for (int k = 0; k < N_IREG; k++) begin
      if (32'(idx) == 32'(IN_START + k)) rd_val = BUS_W'(in_pad[k*REG_W +: REG_W]);
    end
    if (ack_sel) rd_val = BUS_W'(pend);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_val;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/gie_checker.sv
module gie_checker import gie_pkg::*; #(
  parameter int BUS_W    = 16,
  parameter int REG_W    = 8,
  parameter int ADDR_W   = 8,
  parameter int N_OUT    = 12,
  parameter int N_IN     = 10,
  parameter int N_IRQ    = 10,
  parameter int IN_START = 2,
  parameter int ACK_REG  = 4,
  parameter bit INV_ACK  = 1'b0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [BUS_W-1:0]  wdata_i,
  input logic              rd_i,
  input logic              wr_i,
  input logic [BUS_W-1:0]  rdata_o,
  input logic [N_OUT-1:0]  out_pins_o,
  input logic              irq_o,
  input logic [N_IRQ-1:0]  pend
);
  localparam int          SH     = bus_shift(BUS_W);
  localparam int          N_IREG = ceil_div(N_IN, REG_W);
  localparam logic [15:0] PAT    = INV_ACK ? 16'h0000 : 16'hFFFF;

  int unsigned c_idx;
  logic        c_ack, c_mapped_rd;

  assign c_idx       = 32'(addr_i) >> SH;
  assign c_ack       = wr_i && (c_idx == 32'(ACK_REG)) && (wdata_i[15:0] == PAT);
  assign c_mapped_rd = (c_idx == 32'(ACK_REG)) ||
                       ((c_idx >= 32'(IN_START)) && (c_idx < 32'(IN_START + N_IREG)));

  AST_ACK_DROPS_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_ack |=> !irq_o); // R9

  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (pend != '0)); // R9

  AST_PEND_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !c_ack |=> ((pend & $past(pend)) == $past(pend))); // R6

  AST_OUT_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(out_pins_o)); // R3

  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !c_mapped_rd) |=> (rdata_o == '0)); // R11
endmodule

bind gpio_irq_expander gie_checker #(
  .BUS_W   (BUS_W),
  .REG_W   (REG_W),
  .ADDR_W  (ADDR_W),
  .N_OUT   (N_OUT),
  .N_IN    (N_IN),
  .N_IRQ   (N_IRQ),
  .IN_START(IN_START),
  .ACK_REG (ACK_REG),
  .INV_ACK (INV_ACK)
) u_chk (.*);

// File: tb/gpio_irq_expander_test.sv
`timescale 1ns/1ps
module gpio_irq_expander_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [7:0]  a_addr = '0, b_addr = '0;
  logic [15:0] a_wdata = '0, a_rdata;
  logic [31:0] b_wdata = '0, b_rdata;
  logic        a_rd = 0, a_wr = 0, b_rd = 0, b_wr = 0;
  logic [9:0]  a_in = '0, b_in = '0;
  logic [11:0] a_out, b_out;
  logic        a_irq, b_irq;

  gpio_irq_expander uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(a_addr), .wdata_i(a_wdata),
    .rd_i(a_rd), .wr_i(a_wr), .rdata_o(a_rdata), .in_pins_i(a_in),
    .out_pins_o(a_out), .irq_o(a_irq)
  );

  gpio_irq_expander #(.BUS_W(32), .REG_W(16), .INV_ACK(1'b1)) uut_inv (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(b_addr), .wdata_i(b_wdata),
    .rd_i(b_rd), .wr_i(b_wr), .rdata_o(b_rdata), .in_pins_i(b_in),
    .out_pins_o(b_out), .irq_o(b_irq)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  logic [31:0] exp_q[$];
  bit          sel_q[$];
  string       tag_q[$];
  logic        rd_seen = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input bit sel, input logic [7:0] addr, input logic [31:0] data);
    @(negedge clk);
    if (sel) begin b_addr = addr; b_wdata = data; b_wr = 1; end
    else     begin a_addr = addr; a_wdata = data[15:0]; a_wr = 1; end
    @(negedge clk);
    a_wr = 0; b_wr = 0;
  endtask

  task automatic bus_rd(input bit sel, input logic [7:0] addr, input logic [31:0] exp, input string tag);
    @(negedge clk);
    if (sel) begin b_addr = addr; b_rd = 1; end
    else     begin a_addr = addr; a_rd = 1; end
    exp_q.push_back(exp); sel_q.push_back(sel); tag_q.push_back(tag);
    @(negedge clk);
    a_rd = 0; b_rd = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: one read result per sampled strobe
  always @(posedge clk) rd_seen <= a_rd | b_rd;
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [31:0] e, act;
      bit s;
      string t;
      e = exp_q.pop_front(); s = sel_q.pop_front(); t = tag_q.pop_front();
      act = s ? b_rdata : {16'h0, a_rdata};
      chk(act == e, t, act, e);
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(1);
    // reset state
    chk(a_out == 12'h5A3, "R4", a_out, 12'h5A3);
    chk(a_irq == 0, "R12", a_irq, 0);
    chk(a_rdata == 0, "R12", a_rdata, 0);
    bus_rd(0, 8'h08, 32'h0, "R12");
    bus_rd(0, 8'h0C, 32'h0, "R11");

    // output registers, 16-bit bus, 8-bit regs
    bus_wr(0, 8'h02, 32'hABFF);
    chk(a_out == 12'hFA3, "R2", a_out, 12'hFA3);
    bus_wr(0, 8'h00, 32'h1234);
    chk(a_out == 12'hF34, "R3", a_out, 12'hF34);
    bus_wr(0, 8'h01, 32'h0055);
    chk(a_out == 12'hF55, "R1", a_out, 12'hF55);
    bus_wr(0, 8'h0C, 32'hFFFF);
    chk(a_out == 12'hF55, "R11", a_out, 12'hF55);
    idle(2);
    chk(a_out == 12'hF55, "R3", a_out, 12'hF55);

    // inputs and pending
    a_in = 10'h2C5;
    idle(4);
    bus_rd(0, 8'h04, 32'hC5, "R5");
    bus_rd(0, 8'h06, 32'h02, "R2");
    bus_rd(0, 8'h08, 32'h2C5, "R7");
    chk(a_irq == 1, "R9", a_irq, 1);
    bus_wr(0, 8'h08, 32'h1234);
    bus_rd(0, 8'h08, 32'h2C5, "R8");
    chk(a_irq == 1, "R8", a_irq, 1);
    bus_wr(0, 8'h08, 32'hFFFF);
    chk(a_irq == 0, "R9", a_irq, 0);
    bus_rd(0, 8'h08, 32'h0, "R8");

    // falling edges set nothing
    a_in = 10'h000;
    idle(4);
    bus_rd(0, 8'h08, 32'h0, "R6");
    chk(a_irq == 0, "R6", a_irq, 0);

    // steady high does not re-trigger after ack
    a_in = 10'h001;
    idle(4);
    bus_rd(0, 8'h08, 32'h001, "R6");
    bus_wr(0, 8'h08, 32'hFFFF);
    idle(4);
    bus_rd(0, 8'h08, 32'h0, "R6");
    chk(a_irq == 0, "R6", a_irq, 0);

    // event coincident with ack
    a_in = 10'h011;
    @(negedge clk);
    @(negedge clk);
    a_addr = 8'h08; a_wdata = 16'hFFFF; a_wr = 1;
    @(negedge clk);
    a_wr = 0;
    chk(a_irq == 0, "R10", a_irq, 0);
    @(negedge clk);
    chk(a_irq == 1, "R10", a_irq, 1);
    bus_rd(0, 8'h08, 32'h010, "R10");

    // 32-bit bus, 16-bit regs, inverted ack
    chk(b_out == 12'h5A3, "R4", b_out, 12'h5A3);
    bus_wr(1, 8'h00, 32'hFFFF_ABCD);
    chk(b_out == 12'hBCD, "R3", b_out, 12'hBCD);
    bus_wr(1, 8'h02, 32'h0000_0123);
    chk(b_out == 12'h123, "R1", b_out, 12'h123);
    b_in = 10'h3FF;
    idle(4);
    bus_rd(1, 8'h08, 32'h3FF, "R5");
    bus_rd(1, 8'h10, 32'h3FF, "R7");
    bus_rd(1, 8'h04, 32'h0, "R11");
    bus_wr(1, 8'h10, 32'h0000_FFFF);
    bus_rd(1, 8'h10, 32'h3FF, "R8");
    chk(b_irq == 1, "R8", b_irq, 1);
    bus_wr(1, 8'h10, 32'h0);
    chk(b_irq == 0, "R8", b_irq, 0);
    bus_rd(1, 8'h10, 32'h0, "R8");

    idle(3);
    chk(exp_q.size() == 0, "R5", exp_q.size(), 0);
    finish_run();
  end
endmodule